// File: doc/BRIEF.md
# Edge-Selectable GPIO Interrupt Unit

This block monitors sixteen input pins, grouped as two 8-bit ports, and turns chosen signal transitions into interrupt requests. For every pin, software decides whether the pin may interrupt (an enable bit) and which transition counts (rising or falling). Each pin has a sticky flag that records a detected transition until software clears it by writing a one to it. Each port produces one request line toward an external interrupt controller. The line is high while any of that port's flags is set on an enabled pin.

Pins of port 0 pass through a debounce filter before edge detection. The filter length is programmable, with one setting shared by pins 3..0 and another shared by pins 7..4. Pins of port 1 are only synchronised. All pins go through a two-flop synchroniser. Software reaches the registers through a simple bus: a write strobe, an address and write data. Read data is registered.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads 0x00 and both request outputs are low.
- R2: With the edge-select bit at 0, a rising transition on a pin sets that pin's flag, and a falling transition leaves the flag unchanged.
- R3: With the edge-select bit at 1, a falling transition sets the flag, and a rising transition leaves the flag unchanged.
- R4: A flag is set even while its enable bit is 0. A port's request is high one cycle after any of its flags is set on a pin whose enable bit is 1. The request is low whenever no enabled pin has its flag set.
- R5: Writing to a flag register clears each flag whose write-data bit is 1 and leaves the flags whose bit is 0 unchanged. Writing a flag register never sets a flag.
- R6: If a detected transition and a clear of the same flag happen in the same cycle, the flag ends up set.
- R7: Changing an edge-select bit while the pin level is steady does not set the flag.
- R8: A port 0 pin with a filter code k in 1..7 changes its filtered level only after 2^k consecutive samples that differ from the filtered level. A pulse of 2^k−1 cycles is ignored, and a pulse of 2^k cycles is detected.
- R9: Filter code 0 bypasses the filter, so a one-cycle pulse is detected. The filter register holds the code for pins 3..0 in bits [2:0] and the code for pins 7..4 in bits [6:4]. Port 1 pins are never filtered.
- R10: The register offsets are 0x05, 0x06 and 0x07 for the port 0 enable, edge-select and flag registers, and 0x15, 0x16 and 0x17 for the same registers of port 1. The filter register is at 0x08. Read data shows the register at the address presented one cycle earlier. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_pins | input | 8 | Port 0 pins (filtered) |
| p1_pins | input | 8 | Port 1 pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_p0 | output | 1 | Port 0 interrupt request |
| irq_p1 | output | 1 | Port 1 interrupt request |

## Verification
The hardest case to reach from the ports is a detected transition that arrives in the same cycle as a write-one-to-clear of the same flag. The bench counts the two synchroniser stages on port 1 so that the pin change and the bus write meet in exactly that cycle. It then shows that the flag survives. A clear issued one cycle later, as a control, does remove the flag. The filter thresholds are probed at their exact boundary, with pulses of 2^k−1 and 2^k cycles for codes 2 and 7. A behavioural model is compared with both request lines and the read data on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFF_EN0   = 'h05;
  localparam int OFF_SEL0  = 'h06;
  localparam int OFF_FLG0  = 'h07;
  localparam int OFF_FILT  = 'h08;
  localparam int OFF_EN1   = 'h15;
  localparam int OFF_SEL1  = 'h16;
  localparam int OFF_FLG1  = 'h17;
  localparam int HI_FIELD_LSB = 4;

  // transition of the raw level selected by polarity (1 = falling)
  function automatic logic pick_edge(logic sel, logic prev, logic cur);
    return sel ? (prev & ~cur) : (~prev & cur);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_chatter_filt.sv
module gpio_chatter_filt #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              d,
  output logic              q
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] lim;

  // consecutive differing samples needed, minus one
  assign lim = {CNT_W{1'b1}} >> (CNT_W - int'(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      run <= '0;
    end else if (code == '0) begin
      q   <= d;
      run <= '0;
    end else if (d == q) begin
      run <= '0;
    end else if (run == lim) begin
      q   <= d;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic         en_we,
  input  logic         sel_we,
  input  logic         flg_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en,
  output logic [W-1:0] sel,
  output logic [W-1:0] flg,
  output logic [W-1:0] hit,
  output logic         irq
);
  import gpio_irq_pkg::*;

  logic [W-1:0] prev;
  logic [W-1:0] clr;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit[i] = pick_edge(sel[i], prev[i], lvl[i]);
  end

  assign clr = flg_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      en   <= '0;
      sel  <= '0;
      flg  <= '0;
      irq  <= 1'b0;
    end else begin
      prev <= lvl;
      if (en_we)  en  <= wdata;
      if (sel_we) sel <= wdata;
      flg <= (flg & ~clr) | hit;
      irq <= |(flg & en);
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int ADDR_W = 5,
  parameter int PORT_W = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] p0_pins,
  input  logic [PORT_W-1:0] p1_pins,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  output logic              irq_p0,
  output logic              irq_p1
);
  import gpio_irq_pkg::*;

  localparam int HALF = PORT_W / 2;

  logic [PORT_W-1:0] p0_sync, p1_sync, p0_filt;
  logic [PORT_W-1:0] p0_en, p0_sel, p0_flag, p0_hit;
  logic [PORT_W-1:0] p1_en, p1_sel, p1_flag, p1_hit;
  logic [CODE_W-1:0] code_lo, code_hi;
  logic [PORT_W-1:0] rd_nxt;

  function automatic logic hit_addr(logic [ADDR_W-1:0] a, int off);
    return a == ADDR_W'(off);
  endfunction

  gpio_in_sync #(.W(PORT_W)) u_sync0 (.clk(clk), .rst(rst), .d(p0_pins), .q(p0_sync));
  gpio_in_sync #(.W(PORT_W)) u_sync1 (.clk(clk), .rst(rst), .d(p1_pins), .q(p1_sync));

  for (genvar i = 0; i < PORT_W; i++) begin : g_filt
    gpio_chatter_filt #(.CODE_W(CODE_W)) u_filt (
      .clk (clk),
      .rst (rst),
      .code((i < HALF) ? code_lo : code_hi),
      .d   (p0_sync[i]),
      .q   (p0_filt[i])
    );
  end

  gpio_port_core #(.W(PORT_W)) u_p0 (
    .clk(clk), .rst(rst), .lvl(p0_filt),
    .en_we (bus_wr && hit_addr(bus_addr, OFF_EN0)),
    .sel_we(bus_wr && hit_addr(bus_addr, OFF_SEL0)),
    .flg_we(bus_wr && hit_addr(bus_addr, OFF_FLG0)),
    .wdata(bus_wdata), .en(p0_en), .sel(p0_sel), .flg(p0_flag),
    .hit(p0_hit), .irq(irq_p0)
  );

  gpio_port_core #(.W(PORT_W)) u_p1 (
    .clk(clk), .rst(rst), .lvl(p1_sync),
    .en_we (bus_wr && hit_addr(bus_addr, OFF_EN1)),
    .sel_we(bus_wr && hit_addr(bus_addr, OFF_SEL1)),
    .flg_we(bus_wr && hit_addr(bus_addr, OFF_FLG1)),
    .wdata(bus_wdata), .en(p1_en), .sel(p1_sel), .flg(p1_flag),
    .hit(p1_hit), .irq(irq_p1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_lo <= '0;
      code_hi <= '0;
    end else if (bus_wr && hit_addr(bus_addr, OFF_FILT)) begin
      code_lo <= bus_wdata[CODE_W-1:0];
      code_hi <= bus_wdata[HI_FIELD_LSB +: CODE_W];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (hit_addr(bus_addr, OFF_EN0))  rd_nxt = p0_en;
    if (hit_addr(bus_addr, OFF_SEL0)) rd_nxt = p0_sel;
    if (hit_addr(bus_addr, OFF_FLG0)) rd_nxt = p0_flag;
    if (hit_addr(bus_addr, OFF_EN1))  rd_nxt = p1_en;
    if (hit_addr(bus_addr, OFF_SEL1)) rd_nxt = p1_sel;
    if (hit_addr(bus_addr, OFF_FLG1)) rd_nxt = p1_flag;
    if (hit_addr(bus_addr, OFF_FILT)) begin
      rd_nxt[CODE_W-1:0]               = code_lo;
      rd_nxt[HI_FIELD_LSB +: CODE_W]   = code_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int ADDR_W = 5,
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] flag0,
  input logic [PORT_W-1:0] flag1,
  input logic [PORT_W-1:0] hit0,
  input logic [PORT_W-1:0] hit1,
  input logic [PORT_W-1:0] en0,
  input logic              irq_p0
);
  import gpio_irq_pkg::*;

  // R2: a flag only rises where a transition was detected
  a_r2_flag_needs_edge: assert property (@(posedge clk) disable iff (rst)
    ((flag0 & ~$past(flag0) & ~$past(hit0)) == '0) &&
    ((flag1 & ~$past(flag1) & ~$past(hit1)) == '0));

  // R6: a detected transition always leaves its flag set
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (rst)
    ((~flag0 & $past(hit0)) == '0) && ((~flag1 & $past(hit1)) == '0));

  // R5: written ones clear flags that saw no new transition
  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == ADDR_W'(OFF_FLG0)) |->
      ((flag0 & $past(bus_wdata) & ~$past(hit0)) == '0));

  // R4: no enabled pin means no request
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(en0) == '0) |-> !irq_p0);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .flag0(p0_flag), .flag1(p1_flag), .hit0(p0_hit), .hit1(p1_hit),
  .en0(p0_en), .irq_p0(irq_p0)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] p0 = '0, p1 = '0;
  logic       wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq0, irq1;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_edge_irq dut_i (
    .clk(clk), .rst(rst), .p0_pins(p0), .p1_pins(p1), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_p0(irq0), .irq_p1(irq1)
  );

  // behavioural reference model
  logic [7:0] ms1_0, ms2_0, mf0, mpv0, ms1_1, ms2_1, mpv1;
  logic [7:0] men0, men1, msel0, msel1, mflg0, mflg1, mrd;
  logic [2:0] mlo, mhi;
  logic       mirq0, mirq1;
  int         mcnt[8];
  logic [7:0] h0, h1, nf0, c0, c1;
  int         code, lim;

  always @(posedge clk) begin
    if (rst) begin
      {ms1_0, ms2_0, mf0, mpv0, ms1_1, ms2_1, mpv1} = '0;
      {men0, men1, msel0, msel1, mflg0, mflg1, mrd} = '0;
      mlo = '0; mhi = '0; mirq0 = 0; mirq1 = 0;
      for (int i = 0; i < 8; i++) mcnt[i] = 0;
    end else begin
      h0 = (msel0 & mpv0 & ~mf0) | (~msel0 & ~mpv0 & mf0);
      h1 = (msel1 & mpv1 & ~ms2_1) | (~msel1 & ~mpv1 & ms2_1);
      c0 = (wr && addr == 5'h07) ? wdata : 8'h00;
      c1 = (wr && addr == 5'h17) ? wdata : 8'h00;
      nf0 = mf0;
      for (int i = 0; i < 8; i++) begin
        code = (i < 4) ? int'(mlo) : int'(mhi);
        lim = (1 << code) - 1;
        if (code == 0) begin nf0[i] = ms2_0[i]; mcnt[i] = 0; end
        else if (ms2_0[i] == mf0[i]) mcnt[i] = 0;
        else if (mcnt[i] == lim) begin nf0[i] = ms2_0[i]; mcnt[i] = 0; end
        else mcnt[i]++;
      end
      case (addr)
        5'h05: mrd = men0;  5'h06: mrd = msel0; 5'h07: mrd = mflg0;
        5'h15: mrd = men1;  5'h16: mrd = msel1; 5'h17: mrd = mflg1;
        5'h08: mrd = {1'b0, mhi, 1'b0, mlo};
        default: mrd = 8'h00;
      endcase
      mirq0 = |(mflg0 & men0);
      mirq1 = |(mflg1 & men1);
      mflg0 = (mflg0 & ~c0) | h0;
      mflg1 = (mflg1 & ~c1) | h1;
      mpv0 = mf0; mpv1 = ms2_1; mf0 = nf0;
      ms2_0 = ms1_0; ms1_0 = p0; ms2_1 = ms1_1; ms1_1 = p1;
      if (wr) case (addr)
        5'h05: men0 = wdata;  5'h06: msel0 = wdata;
        5'h15: men1 = wdata;  5'h16: msel1 = wdata;
        5'h08: begin mlo = wdata[2:0]; mhi = wdata[6:4]; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (irq0 !== mirq0 || irq1 !== mirq1 || rdata !== mrd) begin
        bad++;
        $display("FAIL R4/R10 model act=%b%b/%h exp=%b%b/%h",
                 irq0, irq1, rdata, mirq0, mirq1, mrd);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(int a, int d);
    addr = a[4:0]; wdata = d[7:0]; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    addr = a[4:0];
    @(negedge clk);
    chk(tag, int'(rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4); rst = 1'b0; cyc(1);
    // R1 reset state
    chk("R1 irq0", int'(irq0), 0); chk("R1 irq1", int'(irq1), 0);
    rd_chk("R1 en0", 'h05, 0);  rd_chk("R1 sel0", 'h06, 0); rd_chk("R1 flg0", 'h07, 0);
    rd_chk("R1 filt", 'h08, 0); rd_chk("R1 en1", 'h15, 0);  rd_chk("R1 sel1", 'h16, 0);
    rd_chk("R1 flg1", 'h17, 0);
    // R10 map
    wr_reg('h05, 'hA5); rd_chk("R10 en0", 'h05, 'hA5);
    wr_reg('h16, 'h3C); rd_chk("R10 sel1", 'h16, 'h3C); rd_chk("R10 sel0", 'h06, 0);
    rd_chk("R10 unmapped", 'h1F, 0);
    wr_reg('h05, 0); wr_reg('h16, 0);
    // R2 rising, R4 masked flag
    p1 = 8'h02; cyc(5); rd_chk("R2 rise", 'h17, 'h02);
    chk("R4 masked", int'(irq1), 0);
    wr_reg('h15, 'h02); cyc(2); chk("R4 enabled", int'(irq1), 1);
    wr_reg('h17, 'hFF); cyc(3); chk("R4 cleared", int'(irq1), 0);
    p1 = 8'h00; cyc(5); rd_chk("R2 fall ignored", 'h17, 0);
    // R3 falling
    wr_reg('h16, 'h04);
    p1 = 8'h04; cyc(5); rd_chk("R3 rise ignored", 'h17, 0);
    p1 = 8'h00; cyc(5); rd_chk("R3 fall", 'h17, 'h04);
    wr_reg('h17, 'hFF);
    // R7 polarity flip on steady level
    p1 = 8'h08; cyc(5); wr_reg('h17, 'hFF); cyc(2);
    wr_reg('h16, 'h0C); cyc(4); wr_reg('h16, 'h04); cyc(4);
    rd_chk("R7 no spurious", 'h17, 0);
    // R5 write-one-to-clear
    p1 = 8'h2A; cyc(5); rd_chk("R5 setup", 'h17, 'h22);
    wr_reg('h17, 'h02); rd_chk("R5 partial clear", 'h17, 'h20);
    cyc(2); chk("R4 or only enabled", int'(irq1), 0);
    wr_reg('h15, 'h22); cyc(2); chk("R4 or", int'(irq1), 1);
    wr_reg('h17, 'hFF); wr_reg('h15, 0);
    // R6 coincident edge and clear
    p1 = 8'h2B; cyc(5); p1 = 8'h2A; cyc(5);
    p1 = 8'h2B; cyc(2); wr_reg('h17, 'h01);
    rd_chk("R6 edge wins", 'h17, 'h01);
    wr_reg('h17, 'h01); rd_chk("R6 control clear", 'h17, 0);
    // R8 filter code 2 on low nibble
    wr_reg('h08, 'h02);
    p0 = 8'h01; cyc(3); p0 = 8'h00; cyc(8); rd_chk("R8 3-cycle glitch", 'h07, 0);
    p0 = 8'h01; cyc(12); rd_chk("R8 4-cycle hold", 'h07, 'h01);
    // R9 bypass on high nibble, low nibble filtered
    p0 = 8'h11; cyc(1); p0 = 8'h01; cyc(6); rd_chk("R9 bypass pulse", 'h07, 'h11);
    p0 = 8'h03; cyc(1); p0 = 8'h01; cyc(8); rd_chk("R9 low nibble filtered", 'h07, 'h11);
    rd_chk("R9 field readback", 'h08, 'h02);
    wr_reg('h07, 'hFF);
    p1 = 8'hAA; cyc(1); p1 = 8'h2A; cyc(5); rd_chk("R9 port1 unfiltered", 'h17, 'h80);
    // R8 code 7 boundary
    wr_reg('h08, 'h72); cyc(4); wr_reg('h07, 'hFF);
    p0 = 8'h21; cyc(127); p0 = 8'h01; cyc(10); rd_chk("R8 127 ignored", 'h07, 0);
    p0 = 8'h21; cyc(128); p0 = 8'h01; cyc(6); rd_chk("R8 128 detected", 'h07, 'h20);
    wr_reg('h05, 'h20); cyc(2); chk("R4 port0 request", int'(irq0), 1);
    cyc(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule